// File: doc/BRIEF.md
# Logical Device I/O Resource Decoder

This block turns the configuration bytes of a set of logical devices into live I/O decode. Each device supplies an activate bit, a high and a low base byte, an interrupt-number byte and a DMA-select byte. From the two base bytes it forms an aligned base address according to the device's class: floppy controller, parallel port, serial port or hardware monitor. Each class has its own alignment and window size. Every bus address presented with a valid strobe is compared against the windows of all active devices.

The result is registered and appears one clock after the address. It consists of a one-hot device select, a hit flag and the offset of the address from the selected device's aligned base. The decoder also produces each device's routed interrupt number and DMA channel, and a three-bit fan-monitor enable vector taken from two device-specific bytes. Device classes are chosen per slot by a parameter. The default slot order is floppy, parallel, serial A, serial B, then the fan-control, voltage-monitor and temperature-monitor windows.

Top module: `ldr_decoder`

## Requirements
- R1: A floppy-class device has base {high[2:0], low[7:3], 3'b000}. It decodes only offsets 2 to 7 of that 8-byte window, so base bytes 0x03/0xF2 select addresses 0x3F2 to 0x3F7 but not 0x3F0 or 0x3F1.
- R2: A parallel-class device has base {high[2:0], low[7:2], 2'b00} and decodes a 4-byte window. Address bits above bit 10 must be zero for a match.
- R3: A serial-class device has base {high[2:0], low[7:3], 3'b000} and decodes all eight bytes of its window.
- R4: A monitor-class device has base {high[7:0], low[7:4], 4'b0000} and decodes a 16-byte window.
- R5: A device whose activate bit is clear never asserts its select, reports interrupt number 0 and reports DMA channel 4, which is the code for no channel.
- R6: When windows overlap, only the lowest-numbered matching active device is selected. At most one select bit is ever high.
- R7: The hit flag is high exactly when a select bit is high. The offset equals the address minus the selected device's aligned base, and is 0 with no hit. Without the valid strobe, no select is made.
- R8: For an active device, the routed interrupt number is bits 3:0 of its interrupt byte and the DMA channel is bits 2:0 of its DMA-select byte.
- R9: Bit 0 of the fan-monitor enable vector is bit 2 of the first fan byte. Bit 1 is bit 5 of the first fan byte. Bit 2 is bit 0 of the second fan byte.
- R10: Every output is registered: it reflects the inputs sampled at the previous rising clock edge. During reset, the selects, hit, offset, interrupt numbers and fan enables are 0 and every DMA channel is 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_valid | input | 1 | Address strobe for the current cycle |
| io_addr | input | ADDR_W | I/O bus address |
| dev_active | input | NUM_DEV | Activate bit per device |
| dev_base_hi | input | 8*NUM_DEV | High base byte per device |
| dev_base_lo | input | 8*NUM_DEV | Low base byte per device |
| dev_irq_num | input | 8*NUM_DEV | Interrupt-number byte per device |
| dev_dma_sel | input | 8*NUM_DEV | DMA-select byte per device |
| fan_cfg_a | input | 8 | First fan-control device byte |
| fan_cfg_b | input | 8 | Second fan-control device byte |
| dev_sel | output | NUM_DEV | One-hot device select |
| dec_hit | output | 1 | Some device was selected |
| dec_offset | output | 4 | Offset from the selected device's aligned base |
| dev_irq | output | 4*NUM_DEV | Routed interrupt number per device |
| dev_dma | output | 3*NUM_DEV | Routed DMA channel per device |
| fan_mon_en | output | 3 | Fan-monitor enable vector |

## Verification
A wrong mask or alignment inside a base former shows up as a select on the wrong address, or as a missing select at a window edge. A wrong priority order shows up as two select bits high, or as the higher-numbered device winning an overlap. Each of these faults becomes visible on dev_sel, dec_hit and dec_offset in the first cycle after the offending address is strobed. A routing slip shows on dev_irq or dev_dma in the cycle after the configuration byte changes.

// File: rtl/ldr_pkg.sv
`timescale 1ns/1ps
package ldr_pkg;

   typedef enum logic [1:0] {
      CLS_FDC = 2'd0,
      CLS_PAR = 2'd1,
      CLS_SER = 2'd2,
      CLS_MON = 2'd3
   } dev_cls_e;

   localparam int unsigned OFF_W    = 4;
   localparam int unsigned BASE_W   = 16;
   localparam logic [2:0]  DMA_NONE = 3'd4;

   function automatic int unsigned cls_win_log2(input dev_cls_e c);
      case (c)
         CLS_PAR: return 2;
         CLS_MON: return 4;
         default: return 3;
      endcase
   endfunction

   function automatic int unsigned cls_min_off(input dev_cls_e c);
      return (c == CLS_FDC) ? 2 : 0;
   endfunction

   function automatic logic [7:0] cls_hi_keep(input dev_cls_e c);
      return (c == CLS_MON) ? 8'hFF : 8'h07;
   endfunction

endpackage

// File: rtl/ldr_window.sv
`timescale 1ns/1ps
module ldr_window
   import ldr_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter logic [1:0]  CLS    = 2'd0
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        base_hi,
   input  logic [7:0]        base_lo,
   output logic              match,
   output logic [OFF_W-1:0]  offset
);
   localparam dev_cls_e     CLASS    = dev_cls_e'(CLS);
   localparam int unsigned  WLOG     = cls_win_log2(CLASS);
   localparam int unsigned  MIN_OFF  = cls_min_off(CLASS);
   localparam logic [7:0]   HI_KEEP  = cls_hi_keep(CLASS);
   localparam logic [7:0]   LO_KEEP  = 8'hFF << WLOG;
   localparam logic [ADDR_W-1:0] WIN_MASK = ADDR_W'((1 << WLOG) - 1);

   generate
      if (WLOG > OFF_W) begin : g_bad_win
         $error("ldr_window: window larger than offset field");
      end
   endgenerate

   logic [ADDR_W-1:0] base_ext;
   logic              page_eq;
   logic              low_ok;

   always_comb begin
      base_ext = ADDR_W'({base_hi & HI_KEEP, base_lo & LO_KEEP});
      page_eq  = (addr >> WLOG) == (base_ext >> WLOG);
      low_ok   = (addr & WIN_MASK) >= ADDR_W'(MIN_OFF);
      match    = page_eq && low_ok;
      offset   = OFF_W'(addr & WIN_MASK);
   end

endmodule

// File: rtl/ldr_priority.sv
`timescale 1ns/1ps
module ldr_priority
   import ldr_pkg::*;
#(
   parameter int unsigned NUM_DEV = 7
) (
   input  logic [NUM_DEV-1:0]       req,
   input  logic [NUM_DEV*OFF_W-1:0] off_flat,
   output logic [NUM_DEV-1:0]       grant,
   output logic                     any,
   output logic [OFF_W-1:0]         off
);
   always_comb begin
      logic found;
      found = 1'b0;
      grant = '0;
      off   = '0;
      for (int i = 0; i < NUM_DEV; i++) begin
         if (req[i] && !found) begin
            found    = 1'b1;
            grant[i] = 1'b1;
            off      = off_flat[i*OFF_W +: OFF_W];
         end
      end
      any = found;
   end

endmodule

// File: rtl/ldr_decoder.sv
`timescale 1ns/1ps
module ldr_decoder
   import ldr_pkg::*;
#(
   parameter int unsigned NUM_DEV       = 7,
   parameter int unsigned ADDR_W        = 16,
   parameter logic [2*NUM_DEV-1:0] DEV_CLASS_MAP =
      {2'd3, 2'd3, 2'd3, 2'd2, 2'd2, 2'd1, 2'd0}
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  io_valid,
   input  logic [ADDR_W-1:0]     io_addr,
   input  logic [NUM_DEV-1:0]    dev_active,
   input  logic [8*NUM_DEV-1:0]  dev_base_hi,
   input  logic [8*NUM_DEV-1:0]  dev_base_lo,
   input  logic [8*NUM_DEV-1:0]  dev_irq_num,
   input  logic [8*NUM_DEV-1:0]  dev_dma_sel,
   input  logic [7:0]            fan_cfg_a,
   input  logic [7:0]            fan_cfg_b,
   output logic [NUM_DEV-1:0]    dev_sel,
   output logic                  dec_hit,
   output logic [OFF_W-1:0]      dec_offset,
   output logic [4*NUM_DEV-1:0]  dev_irq,
   output logic [3*NUM_DEV-1:0]  dev_dma,
   output logic [2:0]            fan_mon_en
);
   generate
      if (NUM_DEV < 1) begin : g_bad_n
         $error("ldr_decoder: NUM_DEV must be at least 1");
      end
      if (ADDR_W < BASE_W || ADDR_W > 32) begin : g_bad_aw
         $error("ldr_decoder: ADDR_W must lie in 16..32");
      end
   endgenerate

   logic [NUM_DEV-1:0]       win_match;
   logic [NUM_DEV-1:0]       win_req;
   logic [NUM_DEV*OFF_W-1:0] win_off;
   logic [NUM_DEV-1:0]       grant_d;
   logic                     any_d;
   logic [OFF_W-1:0]         off_d;
   logic [4*NUM_DEV-1:0]     irq_d;
   logic [3*NUM_DEV-1:0]     dma_d;
   logic [2:0]               fan_d;

   for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
      ldr_window #(
         .ADDR_W (ADDR_W),
         .CLS    (DEV_CLASS_MAP[2*i +: 2])
      ) u_win (
         .addr    (io_addr),
         .base_hi (dev_base_hi[8*i +: 8]),
         .base_lo (dev_base_lo[8*i +: 8]),
         .match   (win_match[i]),
         .offset  (win_off[OFF_W*i +: OFF_W])
      );

      always_comb begin
         win_req[i] = io_valid && dev_active[i] && win_match[i];
         if (dev_active[i]) begin
            irq_d[4*i +: 4] = 4'(dev_irq_num[8*i +: 8] & 8'h0F);
            dma_d[3*i +: 3] = 3'(dev_dma_sel[8*i +: 8] & 8'h07);
         end else begin
            irq_d[4*i +: 4] = 4'd0;
            dma_d[3*i +: 3] = DMA_NONE;
         end
      end
   end

   ldr_priority #(
      .NUM_DEV (NUM_DEV)
   ) u_prio (
      .req      (win_req),
      .off_flat (win_off),
      .grant    (grant_d),
      .any      (any_d),
      .off      (off_d)
   );

   always_comb begin
      fan_d[0] = |(fan_cfg_a & 8'h04);
      fan_d[1] = |(fan_cfg_a & 8'h20);
      fan_d[2] = |(fan_cfg_b & 8'h01);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dev_sel    <= '0;
         dec_hit    <= 1'b0;
         dec_offset <= '0;
         dev_irq    <= '0;
         dev_dma    <= {NUM_DEV{DMA_NONE}};
         fan_mon_en <= '0;
      end else begin
         dev_sel    <= grant_d;
         dec_hit    <= any_d;
         dec_offset <= off_d;
         dev_irq    <= irq_d;
         dev_dma    <= dma_d;
         fan_mon_en <= fan_d;
      end
   end

endmodule

// File: rtl/ldr_decoder_chk.sv
`timescale 1ns/1ps
module ldr_decoder_chk
   import ldr_pkg::*;
#(
   parameter int unsigned NUM_DEV = 7
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 io_valid,
   input logic [NUM_DEV-1:0]   dev_active,
   input logic [NUM_DEV-1:0]   dev_sel,
   input logic                 dec_hit,
   input logic [OFF_W-1:0]     dec_offset,
   input logic [4*NUM_DEV-1:0] dev_irq,
   input logic [3*NUM_DEV-1:0] dev_dma
);
   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dev_sel)); // R6

   AST_HIT_MATCHES_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      dec_hit == (dev_sel != '0)); // R7

   AST_NO_SEL_WITHOUT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(io_valid) |-> (dev_sel == '0)); // R7

   AST_NO_HIT_ZERO_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_hit |-> (dec_offset == '0)); // R7

   for (genvar i = 0; i < NUM_DEV; i++) begin : g_chk
      AST_INACTIVE_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
         dev_sel[i] |-> $past(dev_active[i])); // R5

      AST_INACTIVE_NO_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(dev_active[i]) |->
            (dev_irq[4*i +: 4] == 4'd0 && dev_dma[3*i +: 3] == DMA_NONE)); // R5
   end

endmodule

bind ldr_decoder ldr_decoder_chk #(.NUM_DEV(NUM_DEV)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .io_valid   (io_valid),
   .dev_active (dev_active),
   .dev_sel    (dev_sel),
   .dec_hit    (dec_hit),
   .dec_offset (dec_offset),
   .dev_irq    (dev_irq),
   .dev_dma    (dev_dma)
);

// File: tb/ldr_decoder_tb.sv
`timescale 1ns/1ps
module ldr_decoder_tb;
   localparam int N = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          io_valid = 1'b0;
   logic [15:0]   io_addr = '0;
   logic [N-1:0]  dev_active = '0;
   logic [8*N-1:0] dev_base_hi = '0;
   logic [8*N-1:0] dev_base_lo = '0;
   logic [8*N-1:0] dev_irq_num = '0;
   logic [8*N-1:0] dev_dma_sel = '0;
   logic [7:0]    fan_cfg_a = '0;
   logic [7:0]    fan_cfg_b = '0;
   logic [N-1:0]  dev_sel;
   logic          dec_hit;
   logic [3:0]    dec_offset;
   logic [4*N-1:0] dev_irq;
   logic [3*N-1:0] dev_dma;
   logic [2:0]    fan_mon_en;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #2 clk = ~clk;

   ldr_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_addr(io_addr),
      .dev_active(dev_active), .dev_base_hi(dev_base_hi),
      .dev_base_lo(dev_base_lo), .dev_irq_num(dev_irq_num),
      .dev_dma_sel(dev_dma_sel), .fan_cfg_a(fan_cfg_a),
      .fan_cfg_b(fan_cfg_b), .dev_sel(dev_sel), .dec_hit(dec_hit),
      .dec_offset(dec_offset), .dev_irq(dev_irq), .dev_dma(dev_dma),
      .fan_mon_en(fan_mon_en)
   );

   // entry: {addr[15:0], 5'b0, sel[6:0], offset[3:0]}
   localparam int NV = 18;
   localparam logic [31:0] VEC [NV] = '{
      32'h03F0_0000, 32'h03F1_0000, 32'h03F2_0012, 32'h03F7_0017,
      32'h03F8_0080, 32'h03FF_0087, 32'h0400_0000, 32'h0278_0020,
      32'h027B_0023, 32'h027C_0000, 32'h02F8_0040, 32'h02FF_0047,
      32'h0C00_0100, 32'h0C0F_010F, 32'h0C10_0200, 32'h0C2A_040A,
      32'h0C30_0000, 32'h1278_0000
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic set_dev(input int i, input logic [7:0] hi, input logic [7:0] lo,
                          input logic [7:0] irq, input logic [7:0] dma);
      dev_base_hi[8*i +: 8] = hi;
      dev_base_lo[8*i +: 8] = lo;
      dev_irq_num[8*i +: 8] = irq;
      dev_dma_sel[8*i +: 8] = dma;
   endtask

   // drive at a falling edge; result is visible at the next falling edge
   task automatic cyc(input logic v, input logic [15:0] a);
      @(negedge clk);
      io_valid = v;
      io_addr  = a;
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(4 * 20000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      set_dev(0, 8'h03, 8'hF2, 8'h06, 8'h02);
      set_dev(1, 8'h02, 8'h78, 8'h07, 8'h04);
      set_dev(2, 8'h02, 8'hF8, 8'h03, 8'h04);
      set_dev(3, 8'h03, 8'hF8, 8'h04, 8'h04);
      set_dev(4, 8'h0C, 8'h05, 8'h00, 8'h04);
      set_dev(5, 8'h0C, 8'h1F, 8'h00, 8'h04);
      set_dev(6, 8'h0C, 8'h20, 8'h00, 8'h04);
      dev_active = '1;
      io_valid   = 1'b1;
      io_addr    = 16'h03F2;
      fan_cfg_a  = 8'hFF;
      fan_cfg_b  = 8'hFF;

      // R10: reset state while inputs would otherwise select and route
      repeat (3) @(negedge clk);
      chk("R10 reset sel", 32'(dev_sel), 0);
      chk("R10 reset hit/offset", {dec_hit, dec_offset}, 0);
      chk("R10 reset irq", 32'(dev_irq), 0);
      chk("R10 reset dma", 32'(dev_dma), 32'(21'o4444444));
      chk("R10 reset fan", 32'(fan_mon_en), 0);
      fan_cfg_a = 8'h00;
      fan_cfg_b = 8'h00;
      rst_n = 1'b1;

      // R1-R4, R7: vector walk
      for (int k = 0; k < NV; k++) begin
         cyc(1'b1, VEC[k][31:16]);
         chk($sformatf("R1-4 sel @%h (R1 R2 R3 R4)", VEC[k][31:16]),
             32'(dev_sel), 32'(VEC[k][10:4]));
         chk($sformatf("R7 hit/off @%h", VEC[k][31:16]),
             {dec_hit, dec_offset}, {(VEC[k][10:4] != 0), VEC[k][3:0]});
      end

      // R10: one-cycle latency, output holds until the next edge
      cyc(1'b1, 16'h0278);
      @(negedge clk);
      io_addr = 16'h03F8;
      #1;
      chk("R10 output held before edge", 32'(dev_sel), 32'h02);
      @(negedge clk);
      chk("R10 output after edge", 32'(dev_sel), 32'h08);

      // R7: no strobe, no select
      cyc(1'b0, 16'h03F2);
      chk("R7 no valid sel", 32'(dev_sel), 0);
      chk("R7 no valid hit/off", {dec_hit, dec_offset}, 0);

      // R8: routing of active devices
      set_dev(0, 8'h03, 8'hF2, 8'h16, 8'h0A);
      cyc(1'b1, 16'h03F2);
      chk("R8 irq dev0", 32'(dev_irq[3:0]), 6);
      chk("R8 dma dev0", 32'(dev_dma[2:0]), 2);
      chk("R8 irq dev3", 32'(dev_irq[15:12]), 4);
      chk("R8 dma dev1", 32'(dev_dma[5:3]), 4);

      // R5: deactivated devices
      dev_active[3] = 1'b0;
      dev_active[0] = 1'b0;
      cyc(1'b1, 16'h03F8);
      chk("R5 inactive serial sel", 32'(dev_sel), 0);
      chk("R5 inactive irq", 32'(dev_irq[15:12]), 0);
      chk("R5 inactive dma", 32'(dev_dma[11:9]), 4);
      cyc(1'b1, 16'h03F4);
      chk("R5 inactive floppy sel", 32'(dev_sel), 0);
      chk("R5 inactive floppy irq/dma", {dev_irq[3:0], 1'b0, dev_dma[2:0]}, {4'd0, 1'b0, 3'd4});
      dev_active = '1;

      // R6: overlap, lowest index wins
      set_dev(2, 8'h03, 8'hF8, 8'h03, 8'h04);
      cyc(1'b1, 16'h03FA);
      chk("R6 overlap sel", 32'(dev_sel), 32'h04);
      chk("R6 overlap offset", 32'(dec_offset), 2);
      dev_active[2] = 1'b0;
      cyc(1'b1, 16'h03FA);
      chk("R6 overlap fallback", 32'(dev_sel), 32'h08);
      dev_active = '1;
      set_dev(4, 8'h0C, 8'h10, 8'h00, 8'h04);
      cyc(1'b1, 16'h0C13);
      chk("R6 monitor overlap", {28'd0, dec_offset}, 32'h3);
      chk("R6 monitor overlap sel", 32'(dev_sel), 32'h10);

      // R9: fan enable bit mapping
      fan_cfg_a = 8'h24; fan_cfg_b = 8'h01;
      cyc(1'b1, 16'h0000);
      chk("R9 fan all", 32'(fan_mon_en), 3'b111);
      fan_cfg_a = 8'h20; fan_cfg_b = 8'h00;
      cyc(1'b1, 16'h0000);
      chk("R9 fan mon1", 32'(fan_mon_en), 3'b010);
      fan_cfg_a = 8'hDB; fan_cfg_b = 8'hFE;
      cyc(1'b1, 16'h0000);
      chk("R9 fan other bits", 32'(fan_mon_en), 3'b000);
      fan_cfg_a = 8'h04; fan_cfg_b = 8'h01;
      cyc(1'b1, 16'h0000);
      chk("R9 fan mon0+mon2", 32'(fan_mon_en), 3'b101);

      finish_run();
   end

endmodule